// File: doc/BRIEF.md
# Operand Effective Address Unit

This block resolves the operand of a load-accumulator instruction. A decoder hands it a mode code, the operand field, the address of the following instruction and the current index, base and general register values. The unit works out an effective address, issues zero, one or two reads on a simple synchronous memory port, and returns the resolved address and the operand value with a one-cycle done strobe.

All inputs are sampled in the cycle a request is accepted, and a request is only accepted while the unit is idle. The memory port is a request/address pair whose read data is valid in the cycle after the request. The number of cycles to completion depends on the mode: one cycle with no read, three cycles with one read, five cycles with two chained reads. Addresses are 16 bits wide and every address sum wraps modulo 2^16.

Mode codes (mode_i): 0 direct, 1 indirect, 2 register-direct, 3 register-indirect, 4 immediate, 5 implicit, 6 relative, 7 indexed, 8 base; 9 to 15 are unused.

Top module: `operand_resolver`

## Requirements
- R1: After reset, busy_o, done_o and mem_req_o are 0, and addr_o and operand_o are 0.
- R2: In direct mode (code 0) the unit reads once at field_i. operand_o is the word read and addr_o equals field_i. done_o rises in the third cycle after the accepting clock edge. A memory request is never held for two cycles in a row.
- R3: In indirect mode (code 1) the unit first reads at field_i, then reads again at the word returned. operand_o is the second word and addr_o is the pointer. done_o rises in the fifth cycle after acceptance.
- R4: In register-direct mode (code 2) operand_o equals reg_i, addr_o is 0 and no read is made. done_o rises in the first cycle after acceptance.
- R5: In register-indirect mode (code 3) the unit reads once at the address held in reg_i. operand_o is the word read and addr_o equals reg_i, with three-cycle latency.
- R6: In immediate mode (code 4) operand_o equals field_i, addr_o is 0, no read is made and the latency is one cycle.
- R7: In implicit mode (code 5) operand_o equals imp_src_i, the value from the source fixed by the opcode. addr_o is 0, no read is made and the latency is one cycle.
- R8: In relative mode (code 6) the unit reads once at pc_next_i + field_i modulo 2^16 and returns that word, with three-cycle latency.
- R9: In indexed mode (code 7) the effective address is field_i + idx_i modulo 2^16. In base mode (code 8) it is field_i + base_i modulo 2^16. Each makes one read and returns that word.
- R10: done_o is high for exactly one cycle per request. busy_o is high from the cycle after acceptance through the done cycle, and it drops in the cycle after done. mem_req_o is only high while busy_o is high.
- R11: A request raised while busy_o is high is ignored, and input changes after acceptance do not alter the result or the read addresses.
- R12: Unused mode codes (9 to 15) complete after one cycle with no read, operand_o 0 and addr_o 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request a resolution; taken only while idle |
| mode_i | input | 4 | Addressing mode code |
| field_i | input | ADDR_W | Operand field of the instruction |
| pc_next_i | input | ADDR_W | Address of the following instruction |
| idx_i | input | ADDR_W | Index register value |
| base_i | input | ADDR_W | Base register value |
| reg_i | input | DATA_W | General register value |
| imp_src_i | input | DATA_W | Operand from the opcode-fixed implicit source |
| busy_o | output | 1 | Request in progress |
| done_o | output | 1 | One-cycle strobe: addr_o and operand_o valid |
| addr_o | output | ADDR_W | Resolved effective address |
| operand_o | output | DATA_W | Resolved operand value |
| mem_req_o | output | 1 | Memory read request |
| mem_addr_o | output | ADDR_W | Memory read address |
| mem_rdata_i | input | DATA_W | Read data, valid the cycle after mem_req_o |

## Verification
A fresh request and an active resolution can fall in the same cycle. The bench provokes this by raising req_i with a different mode, field and register value one cycle after a multi-read request is accepted, and dropping it before done. It then judges the outcome at the ports. The operand, the resolved address, the logged read addresses and the read count must all match the first request. busy_o must fall in the cycle after done with no second completion.

// File: rtl/oper_pkg.sv
package oper_pkg;

  typedef enum logic [3:0] {
    M_DIRECT   = 4'd0,
    M_INDIRECT = 4'd1,
    M_REG      = 4'd2,
    M_REG_IND  = 4'd3,
    M_IMM      = 4'd4,
    M_IMPLICIT = 4'd5,
    M_REL      = 4'd6,
    M_INDEXED  = 4'd7,
    M_BASED    = 4'd8
  } mode_e;

  // number of memory reads a mode needs
  typedef enum logic [1:0] {
    K_NONE = 2'd0,
    K_ONE  = 2'd1,
    K_TWO  = 2'd2
  } kind_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_REQ1,
    S_WAIT1,
    S_REQ2,
    S_WAIT2,
    S_DONE
  } state_e;

endpackage

// File: rtl/oper_resize.sv
module oper_resize #(
  parameter int IN_W  = 16,
  parameter int OUT_W = 16
) (
  input  logic [IN_W-1:0]  d_i,
  output logic [OUT_W-1:0] d_o
);

  localparam int DIFF = (OUT_W > IN_W) ? (OUT_W - IN_W) : (IN_W - OUT_W);

  generate
    if (OUT_W == IN_W) begin : g_same
      assign d_o = d_i;
    end else if (OUT_W > IN_W) begin : g_zext
      assign d_o = {{DIFF{1'b0}}, d_i};
    end else begin : g_trunc
      assign d_o = d_i[OUT_W-1:0];
    end
  endgenerate

endmodule

// File: rtl/oper_ea_calc.sv
module oper_ea_calc
  import oper_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic [3:0]        mode_i,
  input  logic [ADDR_W-1:0] field_i,
  input  logic [ADDR_W-1:0] pc_next_i,
  input  logic [ADDR_W-1:0] idx_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_data_i,
  input  logic [DATA_W-1:0] field_data_i,
  input  logic [DATA_W-1:0] imp_src_i,
  output kind_e             kind_o,
  output logic [ADDR_W-1:0] ea_o,
  output logic [DATA_W-1:0] value_o
);

  logic [ADDR_W-1:0] rel_sum;
  logic [ADDR_W-1:0] idx_sum;
  logic [ADDR_W-1:0] base_sum;

  // sums are ADDR_W wide, so carries out of the top bit drop (mod 2^ADDR_W)
  assign rel_sum  = pc_next_i + field_i;
  assign idx_sum  = field_i + idx_i;
  assign base_sum = field_i + base_i;

  always_comb begin
    kind_o  = K_NONE;
    ea_o    = '0;
    value_o = '0;
    case (mode_i)
      M_DIRECT: begin
        kind_o = K_ONE;
        ea_o   = field_i;
      end
      M_INDIRECT: begin
        kind_o = K_TWO;
        ea_o   = field_i;
      end
      M_REG: begin
        value_o = reg_data_i;
      end
      M_REG_IND: begin
        kind_o = K_ONE;
        ea_o   = reg_addr_i;
      end
      M_IMM: begin
        value_o = field_data_i;
      end
      M_IMPLICIT: begin
        value_o = imp_src_i;
      end
      M_REL: begin
        kind_o = K_ONE;
        ea_o   = rel_sum;
      end
      M_INDEXED: begin
        kind_o = K_ONE;
        ea_o   = idx_sum;
      end
      M_BASED: begin
        kind_o = K_ONE;
        ea_o   = base_sum;
      end
      default: begin
        kind_o  = K_NONE;
        ea_o    = '0;
        value_o = '0;
      end
    endcase
  end

endmodule

// File: rtl/oper_ctrl.sv
module oper_ctrl
  import oper_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  req_i,
  input  kind_e kind_i,
  output logic  accept_o,
  output logic  ld_ptr_o,
  output logic  ld_data_o,
  output logic  mem_req_o,
  output logic  busy_o,
  output logic  done_o
);

  state_e state_q, state_d;
  logic   two_q;

  assign accept_o  = (state_q == S_IDLE) && req_i;
  assign mem_req_o = (state_q == S_REQ1) || (state_q == S_REQ2);
  assign ld_ptr_o  = (state_q == S_WAIT1) && two_q;
  assign ld_data_o = ((state_q == S_WAIT1) && !two_q) || (state_q == S_WAIT2);
  assign busy_o    = (state_q != S_IDLE);
  assign done_o    = (state_q == S_DONE);

  always_comb begin
    state_d = state_q;
    case (state_q)
      S_IDLE:  if (req_i) state_d = (kind_i == K_NONE) ? S_DONE : S_REQ1;
      S_REQ1:  state_d = S_WAIT1;
      S_WAIT1: state_d = two_q ? S_REQ2 : S_DONE;
      S_REQ2:  state_d = S_WAIT2;
      S_WAIT2: state_d = S_DONE;
      S_DONE:  state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      two_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept_o) two_q <= (kind_i == K_TWO);
    end
  end

  // R10: done is a single-cycle strobe
  a_r10_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R10: memory is only addressed while a request is in flight
  a_r10_req_in_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> busy_o);

  // R2: each read request lasts one cycle
  a_r2_single_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |=> !mem_req_o);

  // R11: once busy, the unit stays busy until done
  a_r11_stay_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o) |=> busy_o);

  // R3: a loaded pointer is followed at once by the second read
  a_r3_chain_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_ptr_o |=> mem_req_o);

  // R11: no new acceptance while busy
  a_r11_no_accept_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !accept_o);

endmodule

// File: rtl/operand_resolver.sv
module operand_resolver
  import oper_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [3:0]        mode_i,
  input  logic [ADDR_W-1:0] field_i,
  input  logic [ADDR_W-1:0] pc_next_i,
  input  logic [ADDR_W-1:0] idx_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [DATA_W-1:0] reg_i,
  input  logic [DATA_W-1:0] imp_src_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] operand_o,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic [DATA_W-1:0] mem_rdata_i
);

  logic [ADDR_W-1:0] reg_addr;
  logic [ADDR_W-1:0] ptr_addr;
  logic [DATA_W-1:0] field_data;
  kind_e             kind;
  logic [ADDR_W-1:0] ea;
  logic [DATA_W-1:0] value;
  logic              accept, ld_ptr, ld_data;
  logic [ADDR_W-1:0] ea_q;
  logic [DATA_W-1:0] op_q;

  oper_resize #(.IN_W(DATA_W), .OUT_W(ADDR_W)) u_reg2addr (
    .d_i(reg_i), .d_o(reg_addr));

  oper_resize #(.IN_W(DATA_W), .OUT_W(ADDR_W)) u_rd2addr (
    .d_i(mem_rdata_i), .d_o(ptr_addr));

  oper_resize #(.IN_W(ADDR_W), .OUT_W(DATA_W)) u_fld2data (
    .d_i(field_i), .d_o(field_data));

  oper_ea_calc #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_calc (
    .mode_i      (mode_i),
    .field_i     (field_i),
    .pc_next_i   (pc_next_i),
    .idx_i       (idx_i),
    .base_i      (base_i),
    .reg_addr_i  (reg_addr),
    .reg_data_i  (reg_i),
    .field_data_i(field_data),
    .imp_src_i   (imp_src_i),
    .kind_o      (kind),
    .ea_o        (ea),
    .value_o     (value)
  );

  oper_ctrl u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (req_i),
    .kind_i   (kind),
    .accept_o (accept),
    .ld_ptr_o (ld_ptr),
    .ld_data_o(ld_data),
    .mem_req_o(mem_req_o),
    .busy_o   (busy_o),
    .done_o   (done_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ea_q <= '0;
      op_q <= '0;
    end else begin
      if (accept) begin
        ea_q <= ea;
        op_q <= value;
      end else if (ld_ptr) begin
        ea_q <= ptr_addr;
      end
      if (ld_data) op_q <= mem_rdata_i;
    end
  end

  assign addr_o     = ea_q;
  assign mem_addr_o = ea_q;
  assign operand_o  = op_q;

  // R4/R6/R7/R12: a request needing no read completes in the next cycle
  a_r6_noread_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && kind == K_NONE) |=> done_o);

  // R11: the read address cannot move while a read is being issued
  a_r11_addr_steady: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |=> $stable(mem_addr_o));

endmodule

// File: tb/operand_resolver_tb.sv
module operand_resolver_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [3:0]  mode = '0;
  logic [15:0] field = '0, pc_next = '0, idx = '0, base = '0, rg = '0, imp = '0;
  logic        busy, done, mem_req;
  logic [15:0] addr, operand, mem_addr;
  logic [15:0] mem_rdata = '0;

  int n_chk = 0;
  int n_fail = 0;
  int rd_n = 0;
  logic [15:0] rd_log [0:255];
  bit finished = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  operand_resolver u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .mode_i(mode),
    .field_i(field), .pc_next_i(pc_next), .idx_i(idx), .base_i(base),
    .reg_i(rg), .imp_src_i(imp), .busy_o(busy), .done_o(done),
    .addr_o(addr), .operand_o(operand), .mem_req_o(mem_req),
    .mem_addr_o(mem_addr), .mem_rdata_i(mem_rdata));

  function automatic logic [15:0] mf(input logic [15:0] a);
    return (a ^ 16'hA5C3) + {a[7:0], a[15:8]};
  endfunction

  // synchronous memory: data valid the cycle after the request
  always @(posedge clk) begin
    if (mem_req) begin
      mem_rdata <= mf(mem_addr);
      rd_log[rd_n[7:0]] <= mem_addr;
      rd_n <= rd_n + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run_case(input logic [3:0] m, input logic [15:0] f, input logic [15:0] pc,
                          input logic [15:0] ix, input logic [15:0] bs, input logic [15:0] r,
                          input logic [15:0] im, input bit disturb,
                          input logic [15:0] e_addr, input logic [15:0] e_op,
                          input int e_reads, input int e_lat,
                          input logic [15:0] e_a0, input logic [15:0] e_a1, input string tag);
    int start, lat;
    @(negedge clk);
    start = rd_n;
    mode = m; field = f; pc_next = pc; idx = ix; base = bs; rg = r; imp = im; req = 1'b1;
    lat = 0;
    for (int i = 1; i <= 20; i++) begin
      @(negedge clk);
      if (i == 1) begin
        req = disturb;
        chk(busy === 1'b1, {tag, " R10 busy after accept"}, busy, 1);
        if (disturb) begin
          mode = 4'd4; field = 16'hDEAD; rg = 16'h7777; pc_next = 16'h1111; idx = 16'h2222;
        end
      end else if (i == 2) begin
        req = 1'b0;
      end
      if (done) begin
        lat = i;
        break;
      end
    end
    chk(lat == e_lat, {tag, " latency"}, lat, e_lat);
    chk(busy === 1'b1, {tag, " R10 busy at done"}, busy, 1);
    chk(addr === e_addr, {tag, " address"}, addr, e_addr);
    chk(operand === e_op, {tag, " operand"}, operand, e_op);
    chk((rd_n - start) == e_reads, {tag, " read count"}, rd_n - start, e_reads);
    if (e_reads >= 1) chk(rd_log[start[7:0]] === e_a0, {tag, " first read address"}, rd_log[start[7:0]], e_a0);
    if (e_reads >= 2) chk(rd_log[start[7:0] + 8'd1] === e_a1, {tag, " second read address"}, rd_log[start[7:0] + 8'd1], e_a1);
    @(negedge clk);
    chk(done === 1'b0, {tag, " R10 done one cycle"}, done, 0);
    chk(busy === 1'b0, {tag, " R10 idle after done"}, busy, 0);
    chk(operand === e_op, {tag, " operand held"}, operand, e_op);
  endtask

  task automatic t_reset();
    chk(busy === 1'b0, "R1 busy", busy, 0);
    chk(done === 1'b0, "R1 done", done, 0);
    chk(mem_req === 1'b0, "R1 mem_req", mem_req, 0);
    chk(addr === 16'h0, "R1 addr", addr, 0);
    chk(operand === 16'h0, "R1 operand", operand, 0);
  endtask

  task automatic t_direct();
    run_case(4'd0, 16'h0123, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0, 1'b0,
             16'h0123, mf(16'h0123), 1, 3, 16'h0123, 16'h0, "R2 direct");
  endtask

  task automatic t_indirect();
    logic [15:0] p;
    p = mf(16'h0040);
    run_case(4'd1, 16'h0040, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0, 1'b0,
             p, mf(p), 2, 5, 16'h0040, p, "R3 indirect");
  endtask

  task automatic t_reg_modes();
    run_case(4'd2, 16'h0999, 16'h0, 16'h0, 16'h0, 16'hBEEF, 16'h0, 1'b0,
             16'h0, 16'hBEEF, 0, 1, 16'h0, 16'h0, "R4 register direct");
    run_case(4'd3, 16'h0999, 16'h0, 16'h0, 16'h0, 16'h3456, 16'h0, 1'b0,
             16'h3456, mf(16'h3456), 1, 3, 16'h3456, 16'h0, "R5 register indirect");
  endtask

  task automatic t_immediate();
    run_case(4'd4, 16'h00A5, 16'h0, 16'h0, 16'h0, 16'h1234, 16'h0, 1'b0,
             16'h0, 16'h00A5, 0, 1, 16'h0, 16'h0, "R6 immediate");
  endtask

  task automatic t_implicit();
    run_case(4'd5, 16'h00A5, 16'h0, 16'h0, 16'h0, 16'h1234, 16'hC0DE, 1'b0,
             16'h0, 16'hC0DE, 0, 1, 16'h0, 16'h0, "R7 implicit");
  endtask

  task automatic t_relative();
    run_case(4'd6, 16'h0005, 16'h0001, 16'h0, 16'h0, 16'h0, 16'h0, 1'b0,
             16'h0006, mf(16'h0006), 1, 3, 16'h0006, 16'h0, "R8 relative");
    run_case(4'd6, 16'h0005, 16'hFFFE, 16'h0, 16'h0, 16'h0, 16'h0, 1'b0,
             16'h0003, mf(16'h0003), 1, 3, 16'h0003, 16'h0, "R8 relative wrap");
  endtask

  task automatic t_offset_modes();
    run_case(4'd7, 16'h0005, 16'h0, 16'h000A, 16'h0, 16'h0, 16'h0, 1'b0,
             16'h000F, mf(16'h000F), 1, 3, 16'h000F, 16'h0, "R9 indexed");
    run_case(4'd7, 16'hFFF0, 16'h0, 16'h0020, 16'h0, 16'h0, 16'h0, 1'b0,
             16'h0010, mf(16'h0010), 1, 3, 16'h0010, 16'h0, "R9 indexed wrap");
    run_case(4'd8, 16'h0100, 16'h0, 16'h0020, 16'h2000, 16'h0, 16'h0, 1'b0,
             16'h2100, mf(16'h2100), 1, 3, 16'h2100, 16'h0, "R9 base");
  endtask

  task automatic t_busy_request();
    logic [15:0] p;
    p = mf(16'h0777);
    run_case(4'd1, 16'h0777, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0, 1'b1,
             p, mf(p), 2, 5, 16'h0777, p, "R11 request while busy indirect");
    run_case(4'd3, 16'h0, 16'h0, 16'h0, 16'h0, 16'h4321, 16'h0, 1'b1,
             16'h4321, mf(16'h4321), 1, 3, 16'h4321, 16'h0, "R11 request while busy reg indirect");
  endtask

  task automatic t_unused();
    run_case(4'd12, 16'h0555, 16'h0100, 16'h0001, 16'h0002, 16'h9999, 16'h8888, 1'b0,
             16'h0, 16'h0, 0, 1, 16'h0, 16'h0, "R12 unused code 12");
    run_case(4'd15, 16'h0555, 16'h0100, 16'h0001, 16'h0002, 16'h9999, 16'h8888, 1'b0,
             16'h0, 16'h0, 0, 1, 16'h0, 16'h0, "R12 unused code 15");
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_direct();
    t_indirect();
    t_reg_modes();
    t_immediate();
    t_implicit();
    t_relative();
    t_offset_modes();
    t_busy_request();
    t_unused();
    t_direct();
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

endmodule